// File: doc/BRIEF.md
# Predicated SIMD Signed Integer Divider

This block divides the lanes of a packed vector by the lanes of a second vector, treating every lane as a two's-complement signed integer. A 2-bit size code picks the lane width for each operation, either 32 or 64 bits. A per-byte predicate selects which lanes take part in the division. An active lane receives the truncated quotient. An inactive lane keeps the value of the first operand. A zero divisor yields a quotient of zero without any trap. The most-negative value divided by minus one wraps back to the most-negative value.

The operation begins with a one-cycle `start` while `busy` is low. The block captures the operands, the size code and the predicate on that edge. It then runs a restoring radix-2 division in every lane at once, one quotient bit per cycle. When the merged vector is written to `result`, `done` pulses for one cycle. A size code for bytes or halfwords performs no division. It raises `illegal` together with `done` one cycle after `start`, and `result` keeps its previous value.

Top module: `simd_sdiv`

## Requirements
- R1: Size code 2'b10 selects 32-bit lanes, so lane e occupies bits [32e+31:32e]. Size code 2'b11 selects 64-bit lanes, so lane e occupies bits [64e+63:64e].
- R2: Size codes 2'b00 and 2'b01 are illegal. When one is accepted, `done` and `illegal` are both high for exactly the next cycle, `busy` stays low, and `result` is unchanged.
- R3: Lane e is active when predicate bit e*(esize/8) is 1. That bit belongs to the lowest byte of the lane. Every other predicate bit has no effect.
- R4: An inactive lane of `result` equals the same lane of `opA`, bit for bit.
- R5: An active lane whose divisor is zero produces 0, and no flag is raised.
- R6: An active lane produces |a|/|b| truncated toward zero. The quotient is negated when the signs of a and b differ, and the remainder is discarded.
- R7: In an active lane, the most-negative value divided by -1 gives the most-negative value (wrap modulo 2^esize), with no flag.
- R8: `start` is accepted only while `busy` is low. A `start` given while busy changes neither the running operation nor its result.
- R9: After a legal start, `busy` is high until the result is written. `done` is high for one cycle with `busy` low. `result` changes only in a cycle in which `done` is high. After reset, `busy`, `done` and `illegal` are 0 and `result` is 0.
- R10: With no active lane, `result` equals `opA` at either legal size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only while not busy) |
| sizeCode | input | 2 | Lane width code: 10 = 32-bit, 11 = 64-bit, others illegal |
| pred | input | VL/8 | One predicate bit per byte of the vector |
| opA | input | VL | Dividend vector, also the pass-through source |
| opB | input | VL | Divisor vector |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when result is written or the illegal code is flagged |
| illegal | output | 1 | High with done when the size code was illegal |
| result | output | VL | Merged quotient vector, held between operations |

## Verification
The assertions take for granted three things about the inputs: reset is held high from time zero for several edges, `start` is a synchronous level sampled only on rising edges, and the size code and operands matter only in the cycle in which `start` is taken. The stimulus changes every input on the falling edge and holds `start` for a single cycle. It waits for each result to leave the scoreboard before issuing another operation, so two legitimate `done` pulses never fall in adjacent cycles. The busy-time start test deliberately drives a second `start` with other operands and an illegal size code. This checks that the controller ignores it, and not that the inputs stay quiet.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  localparam logic [1:0] SIZE_W32 = 2'b10;
  localparam logic [1:0] SIZE_W64 = 2'b11;

  localparam int MAX_ESIZE = 64;
  localparam int STEP_CNT_W = $clog2(MAX_ESIZE);

  // strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic load;    // capture operands and initialise lanes
    logic step;    // one restoring-division iteration
    logic commit;  // write merged vector into result
  } sdiv_strobe_t;

endpackage

// File: rtl/sdiv_lane.sv
// Unsigned restoring divider of width W; one quotient bit per step strobe.
module sdiv_lane #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvdMag,
  input  logic [W-1:0] dvsMag,
  output logic [W-1:0] quo
);

  logic [W-1:0] quoReg;
  logic [W-1:0] remReg;
  logic [W-1:0] dvsReg;
  logic [W:0]   remShift;
  logic [W:0]   trialSub;
  logic         fits;

  assign remShift = {remReg, quoReg[W-1]};
  assign trialSub = remShift - {1'b0, dvsReg};
  // a borrow into the top bit means the divisor did not fit
  assign fits     = ~trialSub[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      quoReg <= '0;
      remReg <= '0;
      dvsReg <= '0;
    end else if (load) begin
      quoReg <= dvdMag;
      remReg <= '0;
      dvsReg <= dvsMag;
    end else if (step) begin
      quoReg <= {quoReg[W-2:0], fits};
      remReg <= fits ? trialSub[W-1:0] : remShift[W-1:0];
    end
  end

  assign quo = quoReg;

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   sizeCode,
  output sdiv_strobe_t strobes,
  output logic         busy,
  output logic         done,
  output logic         illegal
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_COMMIT
  } ctrl_state_t;

  ctrl_state_t             state;
  logic [STEP_CNT_W-1:0]   stepCnt;
  logic                    wideOp;
  logic                    lastStep;
  logic                    takeLegal;
  logic                    takeIllegal;

  localparam logic [STEP_CNT_W-1:0] LAST_W64 = STEP_CNT_W'(MAX_ESIZE - 1);
  localparam logic [STEP_CNT_W-1:0] LAST_W32 = STEP_CNT_W'(MAX_ESIZE / 2 - 1);

  assign takeLegal   = (state == ST_IDLE) && start && sizeCode[1];
  assign takeIllegal = (state == ST_IDLE) && start && !sizeCode[1];
  assign lastStep    = stepCnt == (wideOp ? LAST_W64 : LAST_W32);

  always_comb begin
    strobes.load   = takeLegal;
    strobes.step   = (state == ST_RUN);
    strobes.commit = (state == ST_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      wideOp  <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (takeLegal) begin
            state   <= ST_RUN;
            stepCnt <= '0;
            wideOp  <= sizeCode[0];
          end else if (takeIllegal) begin
            done    <= 1'b1;
            illegal <= 1'b1;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (lastStep) state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sdiv_datapath.sv
// Even 32-bit slots carry a 64-bit lane that also serves the 64-bit element
// covering that slot pair; odd slots carry a 32-bit-only lane.
module sdiv_datapath
  import sdiv_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  sdiv_strobe_t    strobes,
  input  logic [1:0]      sizeCode,
  input  logic [VL/8-1:0] pred,
  input  logic [VL-1:0]   opA,
  input  logic [VL-1:0]   opB,
  output logic [VL-1:0]   result
);

  localparam int NUM_SLOTS = VL / 32;

  logic [VL-1:0] heldA;
  logic          wideHeld;
  logic [VL-1:0] merged32;
  logic [VL-1:0] merged64;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldA    <= '0;
      wideHeld <= 1'b0;
    end else if (strobes.load) begin
      heldA    <= opA;
      wideHeld <= sizeCode[0];
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gSlot
    logic [31:0] a32, b32, magA32, magB32, quoLo, fixed32;
    logic        neg32, zero32, act32;

    assign a32    = opA[32*k +: 32];
    assign b32    = opB[32*k +: 32];
    assign magA32 = a32[31] ? (~a32 + 32'd1) : a32;
    assign magB32 = b32[31] ? (~b32 + 32'd1) : b32;

    always_ff @(posedge clk) begin
      if (rst) begin
        neg32  <= 1'b0;
        zero32 <= 1'b0;
        act32  <= 1'b0;
      end else if (strobes.load) begin
        neg32  <= a32[31] ^ b32[31];
        zero32 <= (b32 == 32'd0);
        act32  <= pred[4*k];
      end
    end

    if ((k % 2) == 0) begin : gWide
      localparam int J = k / 2;
      logic [63:0] a64, b64, magA64, magB64, dvd, dvs, quo64, fixed64;
      logic        neg64, zero64, act64;

      assign a64    = opA[64*J +: 64];
      assign b64    = opB[64*J +: 64];
      assign magA64 = a64[63] ? (~a64 + 64'd1) : a64;
      assign magB64 = b64[63] ? (~b64 + 64'd1) : b64;
      // 32-bit mode: dividend left-aligned so 32 steps finish the quotient
      assign dvd    = sizeCode[0] ? magA64 : {magA32, 32'd0};
      assign dvs    = sizeCode[0] ? magB64 : {32'd0, magB32};

      sdiv_lane #(.W(64)) uLane (
        .clk    (clk),
        .rst    (rst),
        .load   (strobes.load),
        .step   (strobes.step),
        .dvdMag (dvd),
        .dvsMag (dvs),
        .quo    (quo64)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          neg64  <= 1'b0;
          zero64 <= 1'b0;
          act64  <= 1'b0;
        end else if (strobes.load) begin
          neg64  <= a64[63] ^ b64[63];
          zero64 <= (b64 == 64'd0);
          act64  <= pred[8*J];
        end
      end

      assign quoLo   = quo64[31:0];
      assign fixed64 = zero64 ? 64'd0 : (neg64 ? (~quo64 + 64'd1) : quo64);
      assign merged64[64*J +: 64] = act64 ? fixed64 : heldA[64*J +: 64];
    end else begin : gNarrow
      sdiv_lane #(.W(32)) uLane (
        .clk    (clk),
        .rst    (rst),
        .load   (strobes.load),
        .step   (strobes.step),
        .dvdMag (magA32),
        .dvsMag (magB32),
        .quo    (quoLo)
      );
    end

    assign fixed32 = zero32 ? 32'd0 : (neg32 ? (~quoLo + 32'd1) : quoLo);
    assign merged32[32*k +: 32] = act32 ? fixed32 : heldA[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strobes.commit) begin
      result <= wideHeld ? merged64 : merged32;
    end
  end

endmodule

// File: rtl/simd_sdiv.sv
module simd_sdiv
  import sdiv_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      sizeCode,
  input  logic [VL/8-1:0] pred,
  input  logic [VL-1:0]   opA,
  input  logic [VL-1:0]   opB,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [VL-1:0]   result
);

  sdiv_strobe_t strobes;

  sdiv_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sizeCode (sizeCode),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal)
  );

  sdiv_datapath #(.VL(VL)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .sizeCode (sizeCode),
    .pred     (pred),
    .opA      (opA),
    .opB      (opB),
    .result   (result)
  );

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int VL = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    sizeCode,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic [VL-1:0] result
);

  // R2: illegal is only ever seen together with done
  a_r2_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  // R2: an illegal code leaves result untouched
  a_r2_illegal_keeps_result: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> $stable(result));

  // R2: accepting an illegal code flags it next cycle without going busy
  a_r2_illegal_response: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !sizeCode[1]) |=> (done && illegal && !busy));

  // R8: a legal start taken while idle makes the block busy
  a_r8_legal_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && sizeCode[1]) |=> busy);

  // R9: done is never raised while busy
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: result changes only in a done cycle
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind simd_sdiv sdiv_checker #(.VL(VL)) uChecker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .sizeCode (sizeCode),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .result   (result)
);

// File: tb/tb_simd_sdiv.sv
`timescale 1ns/1ps
module tb_simd_sdiv;

  localparam int VL  = 256;
  localparam int PW  = VL / 8;
  localparam int N32 = VL / 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    sizeCode = 2'b10;
  logic [PW-1:0] pred = '0;
  logic [VL-1:0] opA = '0;
  logic [VL-1:0] opB = '0;
  logic          busy, done, illegal;
  logic [VL-1:0] result;

  simd_sdiv #(.VL(VL)) dut (
    .clk(clk), .rst(rst), .start(start), .sizeCode(sizeCode), .pred(pred),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .illegal(illegal),
    .result(result)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [VL-1:0] res;
    logic          ill;
    string         tag;
  } item_t;

  item_t         sb[$];
  int            checks = 0;
  int            errors = 0;
  logic [VL-1:0] lastRes = '0;
  bit            finished = 0;
  logic          prevDone = 1'b0;

  function automatic logic [VL-1:0] refDiv(logic [1:0] sz, logic [PW-1:0] p,
                                           logic [VL-1:0] a, logic [VL-1:0] b);
    int            esz  = sz[0] ? 64 : 32;
    int            n    = VL / esz;
    logic [63:0]   mask = sz[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    logic [VL-1:0] r    = '0;
    for (int e = 0; e < n; e++) begin
      logic [63:0] ea, eb, ma, mb, qm, qv;
      logic        sa, sb2;
      ea  = 64'(a >> (e * esz)) & mask;
      eb  = 64'(b >> (e * esz)) & mask;
      sa  = sz[0] ? ea[63] : ea[31];
      sb2 = sz[0] ? eb[63] : eb[31];
      ma  = sa  ? ((~ea + 64'd1) & mask) : ea;
      mb  = sb2 ? ((~eb + 64'd1) & mask) : eb;
      if (eb == 64'd0) qv = 64'd0;
      else begin
        qm = ma / mb;
        qv = (sa ^ sb2) ? ((~qm + 64'd1) & mask) : qm;
      end
      if (!p[e * esz / 8]) qv = ea;
      r = r | (VL'(qv) << (e * esz));
    end
    return r;
  endfunction

  function automatic void chk(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // driver: pushes the expected item and issues one start pulse
  task automatic issue(logic [1:0] sz, logic [PW-1:0] p, logic [VL-1:0] a,
                       logic [VL-1:0] b, string tag);
    item_t it;
    while (busy) @(negedge clk);
    it.ill = !sz[1];
    it.res = sz[1] ? refDiv(sz, p, a, b) : lastRes;
    it.tag = tag;
    lastRes = it.res;
    sb.push_back(it);
    sizeCode = sz; pred = p; opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runOp(logic [1:0] sz, logic [PW-1:0] p, logic [VL-1:0] a,
                       logic [VL-1:0] b, string tag);
    issue(sz, p, a, b, tag);
    drain();
  endtask

  // monitor: compares each done pulse against the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prevDone)
        chk(0, "R9 done wider than one cycle", VL'(1), VL'(0));
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R8 unexpected done", result, lastRes);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(result === it.res, it.tag, result, it.res);
          chk(illegal === it.ill, {it.tag, " illegal flag"}, VL'(illegal), VL'(it.ill));
          chk(busy === 1'b0, {it.tag, " R9 busy at done"}, VL'(busy), VL'(0));
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] a, b;
    logic [PW-1:0] p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R9 reset busy", VL'(busy), VL'(0));
    chk(done === 1'b0, "R9 reset done", VL'(done), VL'(0));
    chk(illegal === 1'b0, "R9 reset illegal", VL'(illegal), VL'(0));
    chk(result === '0, "R9 reset result", result, '0);

    // R6 / R1: mixed signs, 32-bit lanes, all active
    a = {N32/4{32'd7, 32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9}};
    b = {N32/4{32'd2, 32'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFE}};
    runOp(2'b10, {N32{4'h1}}, a, b, "R6 mixed sign 32");
    // R6 / R1: mixed signs, 64-bit lanes
    a = {N32/8{64'd1000, 64'hFFFF_FFFF_FFFF_FC18, 64'd1000, 64'hFFFF_FFFF_FFFF_FC18}};
    b = {N32/8{64'd7, 64'd7, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFF9}};
    runOp(2'b11, {N32/2{8'h01}}, a, b, "R6 mixed sign 64");
    // R5: zero divisors in every other lane
    a = {N32{32'h8765_4321}};
    b = {N32/2{32'd0, 32'd3}};
    runOp(2'b10, '1, a, b, "R5 zero divisor 32");
    a = {N32/2{64'h1234_5678_9ABC_DEF0}};
    b = {N32/4{64'd0, 64'hFFFF_FFFF_FFFF_FFFD}};
    runOp(2'b11, '1, a, b, "R5 zero divisor 64");
    // R7: most-negative divided by -1
    runOp(2'b10, '1, {N32{32'h8000_0000}}, {N32{32'hFFFF_FFFF}}, "R7 min by minus one 32");
    runOp(2'b11, '1, {N32/2{64'h8000_0000_0000_0000}}, '1, "R7 min by minus one 64");
    // R10: nothing active
    runOp(2'b10, '0, {N32{32'hCAFE_F00D}}, {N32{32'd5}}, "R10 all inactive 32");
    runOp(2'b11, '0, {N32{32'hDEAD_0001}}, {N32{32'd9}}, "R10 all inactive 64");
    // R3: only non-lowest bytes set, so no lane is active
    runOp(2'b10, {N32{4'hE}}, {N32{32'h0000_0064}}, {N32{32'd10}}, "R3 upper bytes ignored 32");
    runOp(2'b11, {N32/2{8'hFE}}, {N32{32'h0000_0064}}, {N32{32'd10}}, "R3 upper bytes ignored 64");
    // R4: alternating predicate
    runOp(2'b10, {N32/2{8'h01}}, {N32{32'h0000_0100}}, {N32{32'd16}}, "R4 alternating 32");
    runOp(2'b11, {N32/4{16'h0001}}, {N32{32'hFFFF_0100}}, {N32{32'd16}}, "R4 alternating 64");
    // R2: illegal size codes keep the previous result
    runOp(2'b00, '1, {N32{32'd50}}, {N32{32'd5}}, "R2 illegal size 00");
    runOp(2'b01, '1, {N32{32'd60}}, {N32{32'd6}}, "R2 illegal size 01");
    // R8: start while busy is ignored
    issue(2'b11, '1, {N32{32'h0F0F_0F0F}}, {N32{32'd3}}, "R8 start while busy");
    repeat (5) @(negedge clk);
    sizeCode = 2'b10; opA = {N32{32'd99}}; opB = {N32{32'd1}}; pred = '0; start = 1'b1;
    @(negedge clk);
    sizeCode = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    // R1 / R6 / R3: random operands and predicates at both sizes
    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < N32; k++) begin
        a[32*k +: 32] = $urandom;
        b[32*k +: 32] = ($urandom % 8 == 0) ? 32'd0 : ($urandom >> ($urandom % 32));
        if ($urandom % 4 == 0) b[32*k +: 32] = ~b[32*k +: 32];
      end
      p = $urandom;
      runOp(($urandom % 2) ? 2'b11 : 2'b10, p, a, b, "R1 R6 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule